// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block resolves a 48-bit virtual address into a physical address after the translation cache misses. It walks a radix tree of four table levels held in memory. Each table is one 4 KB page of 512 entries, 8 bytes each. The walk begins at a root table base that is sampled when a request is accepted. At each level the walker reads one entry and checks it. The walk stops early when an entry on the second or third level marks a large page. Otherwise it carries on to the leaf level.

A successful walk returns the physical address, the page size and the effective permissions, which combine every entry on the path. If the final entry still needs its accessed or dirty flag set, the walker first writes that entry back to memory as a read-modify-write. A failed walk returns the faulting virtual address and a cause code, and leaves memory untouched. Only one walk is in flight at a time. The memory port carries one access at a time and waits for an acknowledge.

Entry format (bit positions): present 0, writable 1, user 2, accessed 5, dirty 6, page-size 7, no-execute 63, next-table or frame address in 51:12.

Top module: `ptw_top`

## Requirements
- R1: After reset, req_ready is 1 and both rsp_valid and mem_req are 0.
- R2: The level-k read (k = 0 top, 3 leaf) is at the current table base with its low 12 bits cleared, plus 8 times the index. The index is bits 47:39, 38:30, 29:21 or 20:12 of the address, for k = 0..3. The next table base is taken from bits 51:12 of the entry.
- R3: If the page-size bit is set at level 1, the walk ends with rsp_size 2 (1 GB). If it is set at level 2, the walk ends with rsp_size 1 (2 MB). Otherwise the walk ends at level 3 with rsp_size 0 (4 KB), whatever bit 7 of the leaf entry holds.
- R4: On success, rsp_paddr keeps bits 51:n of the final entry and takes bits n-1:0 from the virtual address, with n = 12, 21 or 30 for 4 KB, 2 MB or 1 GB.
- R5: An entry with the present bit clear ends the walk with rsp_fault 1 and rsp_cause 1. No further levels are read, and rsp_fault_va equals the request address.
- R6: A present top-level entry with the page-size bit set ends the walk with rsp_cause 2 (reserved).
- R7: The effective permissions are writable = AND of the writable bits on the path, user = AND of the user bits, and no-execute = OR of the no-execute bits. These are checked once the final entry is reached. A user request without user permission gives cause 3. A write without writable gives cause 4. An execute request with no-execute set gives cause 5. The priority order is 1, 2, 3, 4, 5.
- R8: On success, rsp_w, rsp_u and rsp_x report the effective writable, user and execute (not no-execute) permissions.
- R9: On success, the final entry ends up in memory with accessed set, and with dirty set if the request was a write. This takes exactly one write to that entry's address when a flag changes, and no write otherwise.
- R10: A faulting walk issues no memory write.
- R11: req_ready stays low from acceptance until the response. rsp_valid is high for exactly one cycle, and req_ready returns the cycle after.
- R12: mem_req stays high with a stable address until mem_ack. A walk makes at most four reads: one per level visited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_base | input | 52 | Physical base of the top-level table, sampled on accept |
| req_valid | input | 1 | Walk request |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 48 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_exec | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Walk failed |
| rsp_cause | output | 3 | 0 none, 1 not present, 2 reserved, 3 user, 4 write, 5 execute |
| rsp_fault_va | output | 48 | Faulting virtual address (0 on success) |
| rsp_paddr | output | 52 | Translated physical address (0 on fault) |
| rsp_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| rsp_w | output | 1 | Effective writable |
| rsp_x | output | 1 | Effective executable |
| rsp_u | output | 1 | Effective user access |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 52 | Entry address |
| mem_wdata | output | 64 | Updated entry for the write-back |
| mem_ack | input | 1 | Access completed; read data valid |
| mem_rdata | input | 64 | Entry read from memory |

## Verification
The checker watches the handshakes on every cycle. It confirms that the memory request is held steady until acknowledged, that a walk never exceeds one read per level, that the response strobe lasts one cycle and never overlaps readiness, and that a faulting walk has written nothing. Every write carries a set accessed flag. The correctness of the translation, the size chosen, the cause priority and the exact final contents of the leaf entry are shown only by the bench. It sweeps all three page sizes and every combination of entry permissions and request kinds, with the restriction placed at the top or at the final level. It adds every not-present level and the reserved case, and checks the results against values worked out from the tree it builds.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ENT_W  = 64;
  localparam int B_PRES = 0;
  localparam int B_WR   = 1;
  localparam int B_USR  = 2;
  localparam int B_ACC  = 5;
  localparam int B_DRT  = 6;
  localparam int B_BIG  = 7;
  localparam int B_NOX  = 63;

  typedef enum logic [2:0] {
    CAUSE_NONE  = 3'd0,
    CAUSE_ABSNT = 3'd1,
    CAUSE_RSVD  = 3'd2,
    CAUSE_USER  = 3'd3,
    CAUSE_WRITE = 3'd4,
    CAUSE_EXEC  = 3'd5
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_EVAL, ST_WBACK, ST_RESP
  } walk_st_e;

  typedef struct packed {
    logic w;
    logic u;
    logic nx;
  } perm_t;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 52,
  localparam int VA_W  = OFF_W + LEVELS * IDX_W,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic [PA_W-1:0]  tbl_base,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] lvl,
  output logic [PA_W-1:0]  ent_addr
);
  localparam int ENT_LG = 3;

  // index field for a level: top level takes the highest field
  function automatic logic [IDX_W-1:0] level_index(input logic [VA_W-1:0] va,
                                                   input logic [LVL_W-1:0] l);
    int sh;
    sh = OFF_W + IDX_W * (LEVELS - 1 - int'(l));
    return IDX_W'(va >> sh);
  endfunction

  function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] base,
                                                input logic [IDX_W-1:0] idx);
    logic [PA_W-1:0] a;
    a = base;
    a[OFF_W-1:0] = '0;
    return a | (PA_W'(idx) << ENT_LG);
  endfunction

  assign ent_addr = slot_addr(tbl_base, level_index(vaddr, lvl));
endmodule

// File: rtl/ptw_entry_chk.sv
module ptw_entry_chk
  import ptw_pkg::*;
#(
  parameter int LEVELS = 4,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic [ENT_W-1:0] ent,
  input  logic [LVL_W-1:0] lvl,
  input  perm_t            acc_in,
  input  logic             is_write,
  input  logic             is_exec,
  input  logic             is_user,
  output perm_t            eff,
  output logic             final_lvl,
  output cause_e           cause,
  output logic             need_wb,
  output logic [ENT_W-1:0] wb_ent
);
  logic present, big, at_top, at_leaf;
  logic unused_ent;

  assign present = ent[B_PRES];
  assign big     = ent[B_BIG];
  assign at_top  = (lvl == '0);
  assign at_leaf = (lvl == LVL_W'(LEVELS - 1));

  // permissions narrow along the path
  assign eff.w  = acc_in.w & ent[B_WR];
  assign eff.u  = acc_in.u & ent[B_USR];
  assign eff.nx = acc_in.nx | ent[B_NOX];

  assign final_lvl = at_leaf | (big & !at_top);

  always_comb begin
    cause = CAUSE_NONE;
    if (!present)                   cause = CAUSE_ABSNT;
    else if (big && at_top)         cause = CAUSE_RSVD;
    else if (final_lvl) begin
      if (is_user && !eff.u)        cause = CAUSE_USER;
      else if (is_write && !eff.w)  cause = CAUSE_WRITE;
      else if (is_exec && eff.nx)   cause = CAUSE_EXEC;
    end
  end

  always_comb begin
    wb_ent = ent;
    wb_ent[B_ACC] = 1'b1;
    if (is_write) wb_ent[B_DRT] = 1'b1;
  end
  assign need_wb = (wb_ent != ent);

  assign unused_ent = ^ent;
endmodule

// File: rtl/ptw_phys_calc.sv
module ptw_phys_calc
  import ptw_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 52,
  localparam int VA_W  = OFF_W + LEVELS * IDX_W,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic [ENT_W-1:0] ent,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] lvl,
  output logic [PA_W-1:0]  paddr,
  output logic [LVL_W-1:0] size
);
  // number of untranslated low bits when the walk ends at level l
  function automatic int pass_bits(input logic [LVL_W-1:0] l);
    return OFF_W + IDX_W * (LEVELS - 1 - int'(l));
  endfunction

  function automatic logic [PA_W-1:0] join_addr(input logic [PA_W-1:0] frame,
                                                input logic [VA_W-1:0] va,
                                                input int n);
    logic [PA_W-1:0] hi;
    hi = {PA_W{1'b1}} << n;
    return (frame & hi) | (PA_W'(va) & ~hi);
  endfunction

  assign paddr = join_addr(ent[PA_W-1:0], vaddr, pass_bits(lvl));
  assign size  = LVL_W'(LEVELS - 1) - lvl;
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 52,
  localparam int VA_W  = OFF_W + LEVELS * IDX_W,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PA_W-1:0]   root_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              req_write,
  input  logic              req_exec,
  input  logic              req_user,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [2:0]        rsp_cause,
  output logic [VA_W-1:0]   rsp_fault_va,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [LVL_W-1:0]  rsp_size,
  output logic              rsp_w,
  output logic              rsp_x,
  output logic              rsp_u,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [ENT_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [ENT_W-1:0]  mem_rdata
);
  walk_st_e          state;
  logic [LVL_W-1:0]  lvl_q;
  logic [PA_W-1:0]   base_q;
  logic [VA_W-1:0]   va_q;
  logic              wr_q, ex_q, us_q;
  logic [ENT_W-1:0]  ent_q;
  perm_t             acc_q;
  logic [ENT_W-1:0]  wb_q;

  logic              fault_q;
  cause_e            cause_q;
  logic [VA_W-1:0]   fva_q;
  logic [PA_W-1:0]   pa_q;
  logic [LVL_W-1:0]  size_q;
  perm_t             perm_q;

  logic [PA_W-1:0]   slot_addr;
  perm_t             eff;
  logic              final_lvl;
  cause_e            cause;
  logic              need_wb;
  logic [ENT_W-1:0]  wb_ent;
  logic [PA_W-1:0]   pa_calc;
  logic [LVL_W-1:0]  size_calc;

  // named events for the checker
  logic walk_fault_w, leaf_done_w, step_down_w, accept_w;

  ptw_addr_gen #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_addr (
    .tbl_base (base_q),
    .vaddr    (va_q),
    .lvl      (lvl_q),
    .ent_addr (slot_addr)
  );

  ptw_entry_chk #(.LEVELS(LEVELS)) u_chk_ent (
    .ent       (ent_q),
    .lvl       (lvl_q),
    .acc_in    (acc_q),
    .is_write  (wr_q),
    .is_exec   (ex_q),
    .is_user   (us_q),
    .eff       (eff),
    .final_lvl (final_lvl),
    .cause     (cause),
    .need_wb   (need_wb),
    .wb_ent    (wb_ent)
  );

  ptw_phys_calc #(.LEVELS(LEVELS), .IDX_W(IDX_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_phys (
    .ent   (ent_q),
    .vaddr (va_q),
    .lvl   (lvl_q),
    .paddr (pa_calc),
    .size  (size_calc)
  );

  assign accept_w     = (state == ST_IDLE) && req_valid;
  assign walk_fault_w = (state == ST_EVAL) && (cause != CAUSE_NONE);
  assign leaf_done_w  = (state == ST_EVAL) && (cause == CAUSE_NONE) && final_lvl;
  assign step_down_w  = (state == ST_EVAL) && (cause == CAUSE_NONE) && !final_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      lvl_q   <= '0;
      base_q  <= '0;
      va_q    <= '0;
      wr_q    <= 1'b0;
      ex_q    <= 1'b0;
      us_q    <= 1'b0;
      ent_q   <= '0;
      acc_q   <= '0;
      wb_q    <= '0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_NONE;
      fva_q   <= '0;
      pa_q    <= '0;
      size_q  <= '0;
      perm_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept_w) begin
          va_q   <= req_vaddr;
          wr_q   <= req_write;
          ex_q   <= req_exec;
          us_q   <= req_user;
          base_q <= root_base;
          lvl_q  <= '0;
          acc_q  <= '{w: 1'b1, u: 1'b1, nx: 1'b0};
          state  <= ST_READ;
        end
        ST_READ: if (mem_ack) begin
          ent_q <= mem_rdata;
          state <= ST_EVAL;
        end
        ST_EVAL: begin
          if (walk_fault_w) begin
            fault_q <= 1'b1;
            cause_q <= cause;
            fva_q   <= va_q;
            pa_q    <= '0;
            size_q  <= '0;
            perm_q  <= '{w: 1'b0, u: 1'b0, nx: 1'b1};
            state   <= ST_RESP;
          end else if (leaf_done_w) begin
            fault_q <= 1'b0;
            cause_q <= CAUSE_NONE;
            fva_q   <= '0;
            pa_q    <= pa_calc;
            size_q  <= size_calc;
            perm_q  <= eff;
            wb_q    <= wb_ent;
            state   <= need_wb ? ST_WBACK : ST_RESP;
          end else begin
            acc_q  <= eff;
            base_q <= {ent_q[PA_W-1:OFF_W], {OFF_W{1'b0}}};
            lvl_q  <= lvl_q + 1'b1;
            state  <= ST_READ;
          end
        end
        ST_WBACK: if (mem_ack) state <= ST_RESP;
        ST_RESP:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign rsp_valid    = (state == ST_RESP);
  assign rsp_fault    = fault_q;
  assign rsp_cause    = cause_q;
  assign rsp_fault_va = fva_q;
  assign rsp_paddr    = pa_q;
  assign rsp_size     = size_q;
  assign rsp_w        = perm_q.w;
  assign rsp_u        = perm_q.u;
  assign rsp_x        = !perm_q.nx;

  assign mem_req   = (state == ST_READ) || (state == ST_WBACK);
  assign mem_we    = (state == ST_WBACK);
  assign mem_addr  = slot_addr;
  assign mem_wdata = wb_q;
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
  parameter int LEVELS = 4,
  parameter int PA_W   = 52
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_ack,
  input logic [PA_W-1:0] mem_addr,
  input logic [63:0]     mem_wdata,
  input logic            walk_fault
);
  int   rd_n;
  logic wrote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_n  <= 0;
      wrote <= 1'b0;
    end else if (req_valid && req_ready) begin
      rd_n  <= 0;
      wrote <= 1'b0;
    end else begin
      if (mem_req && mem_ack && !mem_we) rd_n <= rd_n + 1;
      if (mem_req && mem_ack && mem_we)  wrote <= 1'b1;
    end
  end

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R12
  read_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n <= LEVELS);

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R11
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && req_ready));

  // R10
  clean_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> !wrote);

  // R10
  fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_fault |=> !mem_we);

  // R9
  wb_accessed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[5]);
endmodule

bind ptw_top ptw_chk #(.LEVELS(LEVELS), .PA_W(PA_W)) u_ptw_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .walk_fault (walk_fault_w)
);

// File: tb/sim_ptw_top.sv
module sim_ptw_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [51:0] root_base;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_vaddr = '0;
  logic        req_write = 1'b0, req_exec = 1'b0, req_user = 1'b0;
  logic        rsp_valid, rsp_fault, rsp_w, rsp_x, rsp_u;
  logic [2:0]  rsp_cause;
  logic [47:0] rsp_fault_va;
  logic [51:0] rsp_paddr;
  logic [1:0]  rsp_size;
  logic        mem_req, mem_we;
  logic [51:0] mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;

  int n_tests = 0;
  int n_fail  = 0;
  int rd_cnt  = 0;
  int wr_cnt  = 0;
  logic [63:0] mem [logic [51:0]];

  localparam logic [51:0] FRAME = 52'h0_00AB_CDEF_5000;

  always #2 clk = ~clk;

  ptw_top u0 (.*);

  // memory model: one-cycle acknowledge
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt = wr_cnt + 1;
      end else begin
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
        rd_cnt = rd_cnt + 1;
      end
    end else mem_ack <= 1'b0;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [51:0] tbl(input int l);
    return 52'h100000 * (l + 1);
  endfunction

  function automatic logic [51:0] slot(input logic [47:0] va, input int l);
    logic [47:0] idx;
    idx = (va / (48'h1 << (12 + 9 * (3 - l)))) % 512;
    return tbl(l) + 52'(idx) * 8;
  endfunction

  logic [51:0] leaf_addr;
  logic [63:0] leaf_orig;
  logic [51:0] top_addr;
  logic [63:0] top_orig;

  task automatic build(input logic [47:0] va, input int leaf_lvl, input int rlvl,
                       input logic ew, input logic eu, input logic enx,
                       input int np_lvl, input logic ps0, input logic a0, input logic d0);
    mem.delete();
    for (int l = 0; l <= leaf_lvl; l++) begin
      logic [63:0] e;
      e = 64'h7;
      if (l < leaf_lvl) e = e | 64'(tbl(l + 1));
      else begin
        e = e | 64'(FRAME);
        if (l < 3) e[7] = 1'b1;
        e[5] = a0;
        e[6] = d0;
      end
      if (l == rlvl) begin e[1] = ew; e[2] = eu; e[63] = enx; end
      if (l == np_lvl) e[0] = 1'b0;
      if (l == 0 && ps0) e[7] = 1'b1;
      mem[slot(va, l)] = e;
      if (l == leaf_lvl) begin leaf_addr = slot(va, l); leaf_orig = e; end
      if (l == 0) begin top_addr = slot(va, l); top_orig = e; end
    end
  endtask

  task automatic walk(input logic [47:0] va, input logic w, input logic x, input logic u);
    @(negedge clk);
    req_vaddr = va; req_write = w; req_exec = x; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
  endtask

  task automatic after_rsp();
    // R11: ready low while response shown, strobe lasts one cycle
    check(!req_ready, "R11 ready during rsp", 64'(req_ready), 64'h0);
    @(negedge clk);
    check(!rsp_valid && req_ready, "R11 strobe one cycle", {rsp_valid, req_ready}, 64'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int k;
    root_base = tbl(0);
    repeat (3) @(negedge clk);
    // R1
    check(req_ready && !rsp_valid && !mem_req, "R1 reset state",
          {req_ready, rsp_valid, mem_req}, 64'h4);
    rst_n = 1'b1;
    @(negedge clk);
    k = 0;
    for (int sz = 0; sz < 3; sz++)
      for (int rs = 0; rs < 2; rs++)
        for (int ep = 0; ep < 8; ep++)
          for (int rq = 0; rq < 8; rq++) begin
            int leaf_lvl, rlvl, ad, r0, w0, exp_c;
            logic ew, eu, enx, w, x, u, a0, d0;
            logic [47:0] va;
            logic [63:0] exp_leaf;
            logic [51:0] exp_pa, unit;
            leaf_lvl = 3 - sz;
            rlvl = rs ? leaf_lvl : 0;
            ew = ep[0]; eu = ep[1]; enx = ep[2];
            w = rq[0]; x = rq[1]; u = rq[2];
            ad = (ep + rq + sz) % 4; a0 = ad[0]; d0 = ad[1];
            va = {9'(k * 7 + 1), 9'(k * 13 + 2), 9'(k * 29 + 3), 9'(k * 5 + 4), 12'(k * 97 + 5)};
            k++;
            build(va, leaf_lvl, rlvl, ew, eu, enx, 9, 1'b0, a0, d0);
            r0 = rd_cnt; w0 = wr_cnt;
            walk(va, w, x, u);
            exp_c = (u && !eu) ? 3 : (w && !ew) ? 4 : (x && enx) ? 5 : 0;
            // R7
            check(rsp_fault == (exp_c != 0) && rsp_cause == 3'(exp_c), "R7 cause",
                  64'(rsp_cause), 64'(exp_c));
            // R2 R12: one read per level
            check(rd_cnt - r0 == leaf_lvl + 1, "R2 reads per walk",
                  64'(rd_cnt - r0), 64'(leaf_lvl + 1));
            if (exp_c == 0) begin
              unit = 52'h1 << (12 + 9 * sz);
              exp_pa = (FRAME / unit) * unit + 52'(va) % unit;
              check(rsp_size == 2'(sz), "R3 size", 64'(rsp_size), 64'(sz));
              check(rsp_paddr == exp_pa, "R4 paddr", 64'(rsp_paddr), 64'(exp_pa));
              check({rsp_w, rsp_u, rsp_x} == {ew, eu, !enx}, "R8 perms",
                    {rsp_w, rsp_u, rsp_x}, {ew, eu, !enx});
              exp_leaf = leaf_orig | 64'h20 | (w ? 64'h40 : 64'h0);
              check(mem[leaf_addr] == exp_leaf, "R9 leaf flags", mem[leaf_addr], exp_leaf);
              check(wr_cnt - w0 == ((exp_leaf != leaf_orig) ? 1 : 0), "R9 write count",
                    64'(wr_cnt - w0), 64'(exp_leaf != leaf_orig));
            end else begin
              check(wr_cnt == w0 && mem[leaf_addr] == leaf_orig && mem[top_addr] == top_orig,
                    "R10 no write on fault", 64'(wr_cnt - w0), 64'h0);
              check(rsp_fault_va == va, "R5 fault va", 64'(rsp_fault_va), 64'(va));
            end
            after_rsp();
          end
    // R5: absent entry at each level, on 4 KB and 2 MB paths
    for (int lf = 2; lf < 4; lf++)
      for (int np = 0; np <= lf; np++) begin
        int r0, w0;
        logic [47:0] va;
        va = 48'h7F12_3456_789A + 48'(np * 4096 * 513);
        build(va, lf, 0, 1'b0, 1'b0, 1'b1, np, 1'b0, 1'b0, 1'b0);
        r0 = rd_cnt; w0 = wr_cnt;
        walk(va, 1'b1, 1'b1, 1'b1);
        check(rsp_fault && rsp_cause == 3'd1, "R5 absent cause", 64'(rsp_cause), 64'h1);
        check(rd_cnt - r0 == np + 1, "R5 stop reading", 64'(rd_cnt - r0), 64'(np + 1));
        check(rsp_fault_va == va, "R5 fault va", 64'(rsp_fault_va), 64'(va));
        check(wr_cnt == w0, "R10 no write", 64'(wr_cnt - w0), 64'h0);
        after_rsp();
      end
    // R6: big-page bit at top level; absent outranks it
    for (int pr = 0; pr < 2; pr++) begin
      int r0;
      logic [47:0] va;
      va = 48'hA5A5_0000_1234;
      build(va, 3, 0, 1'b1, 1'b1, 1'b0, pr ? 9 : 0, 1'b1, 1'b0, 1'b0);
      r0 = rd_cnt;
      walk(va, 1'b0, 1'b0, 1'b0);
      check(rsp_fault && rsp_cause == 3'(pr ? 2 : 1), "R6 reserved top",
            64'(rsp_cause), 64'(pr ? 2 : 1));
      check(rd_cnt - r0 == 1, "R6 one read", 64'(rd_cnt - r0), 64'h1);
      after_rsp();
    end
    // R3: bit 7 at the leaf level still gives a 4 KB page
    begin
      logic [47:0] va;
      va = 48'h0123_4567_89AB;
      build(va, 3, 3, 1'b1, 1'b1, 1'b0, 9, 1'b0, 1'b1, 1'b1);
      mem[leaf_addr] = leaf_orig | 64'h80;
      walk(va, 1'b0, 1'b0, 1'b0);
      check(!rsp_fault && rsp_size == 2'd0, "R3 leaf bit7 ignored", 64'(rsp_size), 64'h0);
      after_rsp();
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule